// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM read or write burst. A burst is launched by a start pulse that carries the first column, a length code and an ordering choice. From the following clock onward the block presents one column per clock with a valid flag, and it raises a last flag on the final beat of a fixed-length burst. The memory controller sends this stream to the column address pins and uses the last flag to schedule the next command.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside their aligned block of columns. The beats run either in counting order or in exclusive-or order. A full-page burst walks every column of the row, goes on from the top column back to zero, and runs until it is stopped. A stop request (the controller raises it for a burst-stop or a precharge command) ends any burst. A new start on any clock abandons the running burst and begins the new one.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, valid_o and last_o are 0.
- R2: A start_i sampled at a clock edge makes valid_o 1 from the next cycle, and col_o on that cycle equals start_col_i. That cycle is beat 0.
- R3: len_code_i values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. last_o is 1 only on the final beat, and valid_o is 0 on the cycle after it unless a new start is sampled.
- R4: With order_i = 0 (sequential), beat k of a burst of N beats has its low log2(N) bits equal to (start low bits + k) mod N. The upper bits equal those of the start column.
- R5: With order_i = 1 (interleaved), beat k of a fixed burst of N beats equals the start column with its low log2(N) bits XORed with k.
- R6: len_code_i values 4 to 7 select full page. Beat k equals (start + k) mod 256, last_o stays 0, and the burst continues until a stop or a new start.
- R7: In full-page mode order_i has no effect, and the sequence is always sequential.
- R8: stop_i sampled during a burst without start_i makes valid_o 0 from the next cycle. stop_i while idle has no effect.
- R9: start_i sampled during a burst restarts from the new column at beat 0. When start_i and stop_i are sampled together, start_i wins.
- R10: Length and order are captured at start. Changes to len_code_i or order_i during a burst do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load start column and begin a burst |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code (0..3 fixed 1/2/4/8, 4..7 full page) |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest cases to reach are the collisions at burst boundaries. One is a start on the same clock as a final beat. Another is a start together with a stop. A third is a length or order change in the middle of a burst. The stimulus drives each of these on a chosen cycle against a behavioural model that is compared every clock. A full-page burst is started near the top column so that it crosses from 255 to 0 within a few beats.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   // Ordering of beats within a fixed-length burst
   typedef enum logic {
      ORD_SEQ  = 1'b0,
      ORD_XOR  = 1'b1
   } bcg_order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
   parameter int COL_W   = 8,
   parameter int LEN_W   = 3,
   parameter int MAX_LOG = 3
) (
   input  logic [LEN_W-1:0] code_i,
   output logic [COL_W-1:0] mask_o,
   output logic             fixed_o
);
   // codes 0..MAX_LOG are fixed lengths of 2**code beats, the rest full page
   always_comb begin
      fixed_o = (int'(code_i) <= MAX_LOG);
      for (int i = 0; i < COL_W; i++) begin
         mask_o[i] = fixed_o ? (i < int'(code_i)) : 1'b1;
      end
   end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc
   import bcg_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  bcg_order_e       order_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] low;

   always_comb begin
      low   = (order_i == ORD_XOR) ? (base_i ^ beat_i) : (base_i + beat_i);
      col_o = (base_i & ~mask_i) | (low & mask_i);
   end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W          = 8,
   parameter int LEN_W          = 3,
   parameter int MAX_LOG        = 3,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [LEN_W-1:0] len_code_i,
   input  logic             order_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   localparam int NUM_FIXED = MAX_LOG + 1;

   generate
      if (MAX_LOG >= COL_W) begin : g_bad_log
         $error("MAX_LOG must be smaller than COL_W");
      end
      if ((1 << LEN_W) <= NUM_FIXED) begin : g_bad_len
         $error("LEN_W leaves no code for full page");
      end
   endgenerate

   logic             busy;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] base;
   logic [LEN_W-1:0] len_r;
   bcg_order_e       ord_r;
   bcg_order_e       ord_cap;
   logic [COL_W-1:0] mask;
   logic             fixed;
   logic [COL_W-1:0] cap_mask;
   logic             cap_fixed;

   bcg_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG)) u_dec (
      .code_i (len_r),
      .mask_o (mask),
      .fixed_o(fixed)
   );

   bcg_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG)) u_cap_dec (
      .code_i (len_code_i),
      .mask_o (cap_mask),
      .fixed_o(cap_fixed)
   );

   // interleaved order only for fixed lengths; full page forces sequential
   generate
      if (HAS_INTERLEAVE) begin : g_xor
         assign ord_cap = (order_i && cap_fixed) ? ORD_XOR : ORD_SEQ;
      end else begin : g_seq_only
         assign ord_cap = ORD_SEQ;
      end
   endgenerate

   bcg_addr_calc #(.COL_W(COL_W)) u_calc (
      .base_i (base),
      .beat_i (beat),
      .mask_i (mask),
      .order_i(ord_r),
      .col_o  (col_o)
   );

   assign valid_o = busy;
   assign last_o  = busy && fixed && (beat == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         beat  <= '0;
         base  <= '0;
         len_r <= '0;
         ord_r <= ORD_SEQ;
      end else if (start_i) begin
         busy  <= 1'b1;
         beat  <= '0;
         base  <= start_col_i;
         len_r <= len_code_i;
         ord_r <= ord_cap;
      end else if (busy && (stop_i || last_o)) begin
         busy  <= 1'b0;
      end else if (busy) begin
         beat  <= beat + 1'b1;
      end
   end

   // R3
   last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R3
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   // R2
   start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   // R8
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !valid_o);

   // R8
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> !valid_o);

   // R4
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !start_i && !stop_i && !last_o)
      |=> (((col_o ^ $past(col_o)) & ~$past(mask)) == '0));

   // R6
   fullpage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !fixed && !start_i && !stop_i)
      |=> (valid_o && col_o == $past(col_o) + 1'b1));
endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       order_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] col_o;
   logic       valid_o;
   logic       last_o;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   string cur_req = "R1";

   // reference model state
   int  m_busy = 0, m_k = 0, m_base = 0, m_n = 1, m_ord = 0, m_full = 0;

   burst_col_gen uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int exp_col();
      int blk, off;
      if (m_full != 0) return (m_base + m_k) % 256;
      off = m_base % m_n;
      blk = m_base - off;
      if (m_ord != 0) return blk + (off ^ m_k);
      return blk + ((off + m_k) % m_n);
   endfunction

   function automatic int exp_last();
      return (m_busy != 0 && m_full == 0 && m_k == m_n - 1) ? 1 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0;
      end else if (start_i) begin
         m_busy = 1; m_k = 0; m_base = int'(start_col_i);
         m_full = (len_code_i >= 3'd4) ? 1 : 0;
         m_n    = (m_full != 0) ? 256 : (1 << len_code_i);
         m_ord  = (m_full != 0) ? 0 : int'(order_i);
      end else if (m_busy != 0 && (stop_i || exp_last() != 0)) begin
         m_busy = 0;
      end else if (m_busy != 0) begin
         m_k = m_k + 1;
      end
   end

   always @(negedge clk) begin
      int ev, el, ec;
      ev = m_busy;
      el = exp_last();
      ec = exp_col();
      tests++;
      if (int'(valid_o) != ev || int'(last_o) != el ||
          (ev != 0 && int'(col_o) != ec)) begin
         fails++;
         $display("FAIL %s: valid=%0d/%0d last=%0d/%0d col=%0h/%0h (actual/expected)",
                  cur_req, valid_o, ev, last_o, el, col_o, ec);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         fails++;
         $display("FAIL watchdog: cycles=%0d expected<=50000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic launch(input logic [7:0] col, input logic [2:0] len, input logic ord);
      start_i = 1'b1; start_col_i = col; len_code_i = len; order_i = ord;
      step();
      start_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      cur_req = "R1";
      idle(3);
      rst_n = 1'b1;
      idle(3);

      cur_req = "R3";
      for (int l = 0; l < 4; l++) begin
         launch(8'h35, 3'(l), 1'b0);
         idle(10);
      end

      cur_req = "R4";
      launch(8'h2E, 3'd3, 1'b0); idle(10);
      launch(8'hC7, 3'd2, 1'b0); idle(6);

      cur_req = "R5";
      for (int l = 1; l < 4; l++) begin
         launch(8'hA6, 3'(l), 1'b1);
         idle(10);
      end
      launch(8'h5D, 3'd3, 1'b1); idle(10);

      cur_req = "R6";
      launch(8'hFC, 3'd4, 1'b0);
      idle(9);
      stop_i = 1'b1; step(); stop_i = 1'b0;
      idle(3);

      cur_req = "R7";
      launch(8'hFE, 3'd7, 1'b1);
      idle(5);
      stop_i = 1'b1; step(); stop_i = 1'b0;
      idle(3);

      cur_req = "R8";
      launch(8'h40, 3'd3, 1'b0);
      idle(2);
      stop_i = 1'b1; step(); stop_i = 1'b0;
      idle(3);
      stop_i = 1'b1; idle(3); stop_i = 1'b0;
      idle(2);

      cur_req = "R9";
      launch(8'h10, 3'd3, 1'b0);
      idle(3);
      launch(8'h93, 3'd2, 1'b1);
      idle(1);
      stop_i = 1'b1;
      launch(8'h77, 3'd3, 1'b0);
      stop_i = 1'b0;
      idle(6);
      launch(8'h21, 3'd1, 1'b0);
      launch(8'h22, 3'd0, 1'b0);
      launch(8'h23, 3'd0, 1'b0);
      idle(4);

      cur_req = "R10";
      launch(8'h69, 3'd3, 1'b1);
      len_code_i = 3'd0; order_i = 1'b0;
      idle(10);
      launch(8'h02, 3'd1, 1'b0);
      len_code_i = 3'd5; order_i = 1'b1;
      idle(5);

      cur_req = "R2";
      launch(8'hFF, 3'd2, 1'b0);
      idle(6);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule